// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management side of a two-wire management link to an external Ethernet PHY. A host asks for one register access at a time. The request names the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block turns that request into one complete serial management frame. It produces the management clock by dividing the system clock. It controls the shared data line through separate drive-value, drive-enable and receive signals, so the tri-state buffer stays at the pad.

The management clock runs only while a frame is in progress and sits low between frames. A frame is 64 clock periods long:

- 32 one-bits of preamble.
- The start pattern 0,1.
- The two-bit operation code.
- The PHY address, then the register address.
- A two-bit turnaround.
- A 16-bit data field.

All multi-bit fields go out most significant bit first. On a write the master drives the line for the whole frame. On a read it lets go of the line when the turnaround begins, and the PHY answers with the data field. Completion is marked by a single-cycle `done` pulse. The read result stays on `rdata` until a later read frame finishes.

Top module: `mdio_master`

## Requirements
- R1: After reset `busy`, `done`, `mdc`, `mdio_oe` and `rdata` are all 0. While `busy` is low, `mdc` and `mdio_oe` stay low.
- R2: A request (`req` high) is accepted only when `busy` is low. A request raised while a frame is running is dropped: that frame continues unchanged, only one `done` follows, and no further frame starts.
- R3: Every frame opens with 32 driven one-bits of preamble, followed by the start pattern 0 then 1.
- R4: After the start pattern come the operation code, then `req_phy[4:0]`, then `req_reg[4:0]`, each MSB first. The operation code is 0,1 for a write (`req_rd`=0) and 1,0 for a read (`req_rd`=1).
- R5: In a write frame, the turnaround is driven as 1 then 0, followed by `req_wdata[15:0]` MSB first. `mdio_oe` is high for all 64 bits.
- R6: In a read frame, `mdio_oe` is low for the last 18 bits (turnaround and data). `rdata` receives the 16 data bits that follow the turnaround, MSB first, each sampled while `mdc` is high.
- R7: `mdc` has a period of `CLK_DIV` system clocks with `CLK_DIV/2` of them high. Each frame has exactly 64 `mdc` rising edges. `busy` stays high for 64*`CLK_DIV` cycles.
- R8: `mdio_o` and `mdio_oe` change only while `mdc` is low, never between two consecutive `mdc`-high cycles.
- R9: `done` is high for exactly one cycle, in the same cycle that `busy` falls. The line is released and `mdc` is low in that cycle.
- R10: `rdata` changes only in a cycle where `done` is high at the end of a read frame. Write frames and newly accepted requests leave it untouched.
- R11: A request that is present in the `done` cycle is accepted at the next clock edge, so frames can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request a management frame |
| req_rd | input | 1 | 1 = read frame, 0 = write frame |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Value for a write frame |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends |
| rdata | output | 16 | Result of the last completed read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line receive value |

## Verification
Two events can fall in one cycle: the completion of a read frame, which updates `rdata` and pulses `done`, and the acceptance of a new request. The bench provokes this by holding `req` high through the end of a read and changing the request fields in the `done` cycle itself. It then checks three things: `rdata` holds the first result, `busy` is high again one cycle later, and the second read returns its own register value without disturbing the first result before it completes.

// File: rtl/mdio_pkg.sv
// Package: shared frame constants for the management master.
// Assumes the standard 5-bit address fields and 16-bit data field.
package mdio_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 16;
    localparam logic [1:0]  START_PAT = 2'b01;
    localparam logic [1:0]  OPC_WRITE = 2'b01;
    localparam logic [1:0]  OPC_READ  = 2'b10;
    localparam logic [1:0]  TA_WRITE  = 2'b10;
endpackage

// File: rtl/mdio_clk_div.sv
// Module: management clock divider and bit-phase strobes.
// While run is high a phase counter walks 0..CLK_DIV-1 once per bit.
// mdc is low for the first half of the count and high for the second.
// Assumes CLK_DIV even, >= 4, and DRV_DLY + 1 < CLK_DIV/2, so that a
// driven change becomes visible while mdc is still low.
module mdio_clk_div #(
    parameter int unsigned CLK_DIV = 8,
    parameter int unsigned DRV_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic drv_stb,
    output logic smp_stb,
    output logic bit_end
);
    localparam int unsigned HALF = CLK_DIV / 2;
    localparam int unsigned CW   = $clog2(CLK_DIV);

    logic [CW-1:0] phase;
    logic [CW-1:0] phase_nxt;

    // Next phase: wraps at the end of each bit period.
    always_comb begin
        if (phase == CW'(CLK_DIV - 1)) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase + 1'b1;
        end
    end

    // Phase counter and registered clock output; both park at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase <= '0;
            mdc   <= 1'b0;
        end else begin
            phase <= phase_nxt;
            mdc   <= (phase_nxt >= CW'(HALF));
        end
    end

    // Strobes marking the drive point, the sample point and the bit end.
    assign drv_stb = run && (phase == CW'(DRV_DLY));
    assign smp_stb = run && (phase == CW'(HALF));
    assign bit_end = run && (phase == CW'(CLK_DIV - 1));
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer and line driver.
// Loads the whole outgoing frame into a shift register when a request is
// accepted, then shifts out one bit per drive strobe. Read frames drop the
// drive enable from the turnaround onward. Assumes the strobes come from
// mdio_clk_div running on the same busy flag.
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int unsigned PRE_BITS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              drv_stb,
    input  logic              bit_end,
    output logic              busy,
    output logic              done,
    output logic              rd_active,
    output logic              cap_en,
    output logic              frame_end,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam int unsigned HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int unsigned FRAME_BITS = HDR_BITS + 2 + DATA_W;
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] HDR_END   = IDX_W'(HDR_BITS);
    localparam logic [IDX_W-1:0] DATA_IDX  = IDX_W'(HDR_BITS + 2);

    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] frame_img;
    logic [IDX_W-1:0]      bit_idx;
    logic                  accept;

    // Request is taken only while idle.
    assign accept = req && !busy;

    // Complete frame image built from the request fields.
    always_comb begin
        frame_img = {{PRE_BITS{1'b1}}, START_PAT,
                     (req_rd ? OPC_READ : OPC_WRITE), req_phy, req_reg,
                     (req_rd ? 2'b00 : TA_WRITE),
                     (req_rd ? {DATA_W{1'b0}} : req_wdata)};
    end

    // Frame-end and read-data capture window for the capture stage.
    assign frame_end = busy && bit_end && (bit_idx == LAST_IDX);
    assign cap_en    = busy && rd_active && (bit_idx >= DATA_IDX);

    // Sequencer: accept, shift out, release and signal completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            done      <= 1'b0;
            rd_active <= 1'b0;
            bit_idx   <= '0;
            tx_sr     <= '0;
            mdio_o    <= 1'b0;
            mdio_oe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy      <= 1'b1;
                rd_active <= req_rd;
                bit_idx   <= '0;
                tx_sr     <= frame_img;
            end else if (busy) begin
                if (drv_stb) begin
                    mdio_o  <= tx_sr[FRAME_BITS-1];
                    mdio_oe <= !rd_active || (bit_idx < HDR_END);
                    tx_sr   <= tx_sr << 1;
                end
                if (bit_end) begin
                    if (bit_idx == LAST_IDX) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        mdio_o  <= 1'b0;
                        mdio_oe <= 1'b0;
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdio_rx_capture.sv
// Module: read-data capture.
// Shifts the receive line in at each sample strobe inside the data window
// and commits the assembled word to rdata when a read frame ends.
// Assumes cap_en covers exactly DATA_W sample strobes.
module mdio_rx_capture
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_stb,
    input  logic              cap_en,
    input  logic              mdio_i,
    input  logic              commit,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] rx_sr;

    // Shift register for incoming bits, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (smp_stb && cap_en) begin
            rx_sr <= {rx_sr[DATA_W-2:0], mdio_i};
        end
    end

    // Result register, updated only at the end of a read frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (commit) begin
            rdata <= rx_sr;
        end
    end
endmodule

// File: rtl/mdio_master.sv
// Module: management frame master top level.
// Wires the clock divider, the frame sequencer and the read capture.
// One frame at a time; the pad tri-state buffer lives outside.
module mdio_master #(
    parameter int unsigned CLK_DIV  = 8,
    parameter int unsigned DRV_DLY  = 1,
    parameter int unsigned PRE_BITS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req,
    input  logic        req_rd,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic drv_stb;
    logic smp_stb;
    logic bit_end;
    logic rd_active;
    logic cap_en;
    logic frame_end;
    logic commit;

    // Read result is committed only at the end of a read frame.
    assign commit = frame_end && rd_active;

    mdio_clk_div #(
        .CLK_DIV (CLK_DIV),
        .DRV_DLY (DRV_DLY)
    ) i_clk_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .mdc     (mdc),
        .drv_stb (drv_stb),
        .smp_stb (smp_stb),
        .bit_end (bit_end)
    );

    mdio_frame_seq #(
        .PRE_BITS (PRE_BITS)
    ) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_rd    (req_rd),
        .req_phy   (req_phy),
        .req_reg   (req_reg),
        .req_wdata (req_wdata),
        .drv_stb   (drv_stb),
        .bit_end   (bit_end),
        .busy      (busy),
        .done      (done),
        .rd_active (rd_active),
        .cap_en    (cap_en),
        .frame_end (frame_end),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    mdio_rx_capture i_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp_stb (smp_stb),
        .cap_en  (cap_en),
        .mdio_i  (mdio_i),
        .commit  (commit),
        .rdata   (rdata)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Module: protocol checker bound to mdio_master.
// Watches only top-level ports; assumes synchronous active-low reset.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic [15:0] rdata
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe)); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R9
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R9
    AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdata) |-> done); // R10
endmodule

bind mdio_master mdio_master_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rdata   (rdata)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
    localparam int DIV  = 8;
    localparam int NBIT = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_rd = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
    logic [15:0] rdata;

    int n_chk = 0;
    int n_fail = 0;

    // PHY model state
    logic [15:0] regs [0:1023];
    logic [63:0] sh = '0, oe_sh = '0;
    int          r = 0;
    logic        p_rd = 1'b0;
    logic [9:0]  p_idx = '0;
    logic        phy_oe = 1'b0, phy_d = 1'b1;
    logic        mdc_p = 1'b0, o_p = 1'b0, oe_p = 1'b0;
    int          hi_len = 0, since_rise = 0;
    int          mdc_bad = 0, edge_bad = 0, cont_bad = 0, n_done = 0;
    int          cyc_total = 0;

    assign mdio_i = phy_oe ? phy_d : 1'b1;

    always #2 clk = ~clk;

    mdio_master #(.CLK_DIV(DIV), .DRV_DLY(1), .PRE_BITS(32)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .req(req), .req_rd(req_rd),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string tag, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // PHY model and line monitors, all sampled at the falling system clock.
    always @(negedge clk) begin
        if (done) n_done++;
        if (phy_oe && mdio_oe) cont_bad++;
        if (mdc && mdc_p && (mdio_o !== o_p || mdio_oe !== oe_p)) edge_bad++;
        if (!busy) begin
            r = 0; phy_oe = 1'b0; hi_len = 0; since_rise = 0;
        end else begin
            since_rise++;
            if (mdc) hi_len++;
            if (mdc && !mdc_p) begin
                if (r > 0 && since_rise != DIV) mdc_bad++;
                since_rise = 0;
                sh    = {sh[62:0], (mdio_oe ? mdio_o : mdio_i)};
                oe_sh = {oe_sh[62:0], mdio_oe};
                r++;
                if (r == 46) begin
                    p_rd  = (sh[11:10] == 2'b10);
                    p_idx = {sh[9:5], sh[4:0]};
                end
                if (r == NBIT && !p_rd) regs[p_idx] = sh[15:0];
            end
            if (!mdc && mdc_p) begin
                if (hi_len != DIV/2) mdc_bad++;
                hi_len = 0;
                if (p_rd && r == 47) begin
                    phy_oe = 1'b1; phy_d = 1'b0;
                end else if (p_rd && r >= 48 && r < NBIT) begin
                    phy_oe = 1'b1; phy_d = regs[p_idx][63 - r];
                end else begin
                    phy_oe = 1'b0;
                end
            end
        end
        mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
    end

    // Watchdog: a hung run is one failed check, then the summary.
    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total == 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected done", cyc_total);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // Present one request, wait for done; returns busy-cycle count.
    task automatic run_frame(input logic rd, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [15:0] wd,
                             output int cyc);
        @(negedge clk);
        req = 1'b1; req_rd = rd; req_phy = phy; req_reg = rg; req_wdata = wd;
        @(negedge clk);
        req = 1'b0;
        cyc = 0;
        while (!done) begin
            if (busy) cyc++;
            @(negedge clk);
        end
    endtask

    function automatic logic [45:0] hdr(input logic rd, input logic [4:0] phy,
                                        input logic [4:0] rg);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg};
    endfunction

    // {read, phy, reg, data}: write data, or expected read value
    localparam logic [26:0] VECS [0:8] = '{
        {1'b0, 5'd1,  5'd0,  16'hA5C3},
        {1'b0, 5'd31, 5'd31, 16'hFFFF},
        {1'b0, 5'd0,  5'd5,  16'h0000},
        {1'b1, 5'd1,  5'd0,  16'hA5C3},
        {1'b1, 5'd31, 5'd31, 16'hFFFF},
        {1'b1, 5'd0,  5'd5,  16'h0000},
        {1'b0, 5'd10, 5'd21, 16'h8001},
        {1'b1, 5'd10, 5'd21, 16'h8001},
        {1'b1, 5'd3,  5'd7,  16'h1067}
    };

    initial begin
        int cyc;
        logic [15:0] last_rd;
        int d0;
        for (int i = 0; i < 1024; i++) regs[i] = 16'h1000 + 16'(i);

        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1", {busy, done, mdc, mdio_oe}, 4'b0000, "idle outputs in reset");
        chk("R1", rdata, 16'h0000, "rdata in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", {busy, mdc, mdio_oe}, 3'b000, "idle outputs after reset");
        last_rd = 16'h0000;

        // Table walk
        for (int v = 0; v < 9; v++) begin
            logic        rd;
            logic [4:0]  ph, rg;
            logic [15:0] dt;
            {rd, ph, rg, dt} = VECS[v];
            run_frame(rd, ph, rg, dt, cyc);
            chk("R7", cyc, 64'(NBIT * DIV), "busy cycles per frame");
            chk("R7", r, 64'(NBIT), "mdc rising edges per frame");
            chk("R3", sh[63:32], 32'hFFFF_FFFF, "preamble");
            chk("R4", sh[63:18], hdr(rd, ph, rg), "header bits");
            chk("R9", {busy, mdc, mdio_oe}, 3'b000, "released at done");
            if (!rd) begin
                chk("R5", sh[17:0], {2'b10, dt}, "write turnaround and data");
                chk("R5", oe_sh, {64{1'b1}}, "write drive enable");
                chk("R10", rdata, last_rd, "rdata held over write");
            end else begin
                chk("R6", oe_sh[17:0], 18'h0, "read released");
                chk("R6", oe_sh[63:18], {46{1'b1}}, "read header driven");
                chk("R6", rdata, dt, "read data");
                last_rd = dt;
            end
            @(negedge clk);
            chk("R9", done, 1'b0, "done single cycle");
        end

        // R2: request while busy is dropped
        d0 = n_done;
        @(negedge clk);
        req = 1'b1; req_rd = 1'b0; req_phy = 5'd7; req_reg = 5'd9; req_wdata = 16'h3C5A;
        @(negedge clk);
        req = 1'b0;
        repeat (100) @(negedge clk);
        req = 1'b1; req_rd = 1'b1; req_phy = 5'd2; req_reg = 5'd2;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        chk("R2", sh[63:18], hdr(1'b0, 5'd7, 5'd9), "frame unchanged");
        chk("R2", sh[15:0], 16'h3C5A, "write data unchanged");
        repeat (600) @(negedge clk);
        chk("R2", n_done - d0, 1, "one done only");
        chk("R2", busy, 1'b0, "no extra frame");

        // R11: back-to-back reads, request held through done
        @(negedge clk);
        req = 1'b1; req_rd = 1'b1; req_phy = 5'd1; req_reg = 5'd0;
        @(negedge clk);
        while (!done) @(negedge clk);
        chk("R6", rdata, 16'hA5C3, "first back-to-back read");
        req_phy = 5'd31; req_reg = 5'd31;
        @(negedge clk);
        req = 1'b0;
        chk("R11", busy, 1'b1, "accepted in done cycle");
        chk("R10", rdata, 16'hA5C3, "rdata held at new accept");
        while (!done) @(negedge clk);
        chk("R11", rdata, 16'hFFFF, "second back-to-back read");
        chk("R4", sh[63:18], hdr(1'b1, 5'd31, 5'd31), "second header");

        repeat (4) @(negedge clk);
        chk("R7", mdc_bad, 0, "mdc period and high time");
        chk("R8", edge_bad, 0, "line changes while mdc high");
        chk("R6", cont_bad, 0, "drive contention with phy");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule